// File: doc/BRIEF.md
# Final Trigger Decision Merger

This block is the last stage of a layered calorimeter trigger. It takes one summary word from the barrel section and one from the endcap section and reduces them to a 7-bit trigger word. The word holds a jet class, a high-tower (HT) class, a total-energy flag and a separate jet code for the endcap alone.

The jet and HT classes are the larger of the two sections' classes, clipped to a range with two thresholds (00, 01, 10). The top code 11 is kept for two upgrade rules:

- The jet field goes to 11 when an edge jet patch in the barrel and one in the endcap are both active next to each other.
- The HT field goes to 11 when the merged tower multiplicity reaches two at the low threshold.

The endcap multiplicity is merged with the barrel multiplicity by a bitwise OR. The endcap jet code is worked out from three per-patch classes, and a rule for adjacent patches can raise it to its top value.

The block takes a new pair of words on each cycle where `in_valid` is high. It registers the result with a latency of one cycle and raises `trig_valid` with it.

Top module: `trig_merge_final`

## Requirements
- R1: While `rst_n` is low, `trig_word` and `trig_valid` are zero.
- R2: `trig_valid` is high exactly one cycle after a cycle with `in_valid` high, and low otherwise.
- R3: Jet field `trig_word[1:0]` is min(max(barrel jet class `bar_word[1:0]`, endcap jet code), 2) when the adjacency rule of R4 does not apply.
- R4: Jet field is 11 when the barrel edge flag `bar_word[14]` and the endcap edge flag `end_word[10]` are both 1.
- R5: HT field `trig_word[3:2]` is min(max(barrel HT class `bar_word[3:2]`, endcap HT class `end_word[7:6]`), 2) when R6 does not apply.
- R6: The merged multiplicity is `bar_word[5:4] | end_word[9:8]`. The HT field is 11 when the merged value is 2 or more (bit 1 set); a sum is never formed.
- R7: `trig_word[4]` is 1 only when barrel energy `bar_word[13:6]` is strictly greater than `etot_thr`.
- R8: Endcap code `trig_word[6:5]` is worked out from the patch classes A=`end_word[1:0]`, B=`[3:2]` and C=`[5:4]`:
  - 11 if any patch class is 3, or if two adjacent patches (A,B or B,C) are both 2 or more.
  - Otherwise 10 if any patch class is 2 or more.
  - Otherwise 01 if any patch class is 1 or more.
  - Otherwise 00.
- R9: On a cycle with `in_valid` low, `trig_word` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input words are valid this cycle |
| bar_word | input | 15 | Barrel summary: jet[1:0], HT[3:2], mult[5:4], energy[13:6], edge[14] |
| end_word | input | 11 | Endcap summary: A[1:0], B[3:2], C[5:4], HT[7:6], mult[9:8], edge[10] |
| etot_thr | input | 8 | Barrel total-energy threshold |
| trig_word | output | 7 | {endcap code[6:5], energy flag[4], HT[3:2], jet[1:0]} |
| trig_valid | output | 1 | trig_word updated this cycle |

## Verification
The barrel and endcap classes are driven one at a time and together. This shows that each field takes the maximum and clips class 3 down to 10. Edge flags are set singly and then both together, which separates the jet upgrade from a plain maximum. Multiplicity pairs 01/01 and 01/10 tell an OR apart from a sum. Patch patterns for the endcap code place class-2 patches next to each other and apart, so the adjacency rule is exercised on its own. An energy equal to the threshold shows that the comparison is strict.

// File: rtl/trig_merge_pkg.sv
package trig_merge_pkg;
    localparam int CLS_W    = 2;
    localparam int MULT_W   = 2;
    localparam int N_EPATCH = 3;
    localparam logic [CLS_W-1:0] CLS_TOP  = 2'd3;
    localparam logic [CLS_W-1:0] CLS_CLIP = 2'd2;

    typedef struct packed {
        logic [CLS_W-1:0] ee_code;
        logic             etot_hit;
        logic [CLS_W-1:0] ht_cls;
        logic [CLS_W-1:0] jet_cls;
    } trig_out_t;

    typedef struct packed {
        logic      valid;
        trig_out_t word;
    } trig_state_t;
endpackage

// File: rtl/tmf_ecap_jet_coder.sv
module tmf_ecap_jet_coder
    import trig_merge_pkg::*;
#(
    parameter int N_PATCH = N_EPATCH
) (
    input  logic [N_PATCH*CLS_W-1:0] patch_cls,
    output logic [CLS_W-1:0]         code
);
    logic [N_PATCH-1:0] ge1, ge2, ge3;
    logic [N_PATCH-2:0] pair_hi;

    genvar gi;
    generate
        for (gi = 0; gi < N_PATCH; gi++) begin : g_lvl
            assign ge1[gi] = patch_cls[gi*CLS_W +: CLS_W] >= 2'd1;
            assign ge2[gi] = patch_cls[gi*CLS_W +: CLS_W] >= 2'd2;
            assign ge3[gi] = patch_cls[gi*CLS_W +: CLS_W] == 2'd3;
        end
        for (gi = 0; gi < N_PATCH-1; gi++) begin : g_pair
            assign pair_hi[gi] = ge2[gi] & ge2[gi+1];
        end
    endgenerate

    always_comb begin
        if ((|ge3) || (|pair_hi)) code = 2'd3;
        else if (|ge2)            code = 2'd2;
        else if (|ge1)            code = 2'd1;
        else                      code = 2'd0;
    end
endmodule

// File: rtl/tmf_class_merge.sv
module tmf_class_merge
    import trig_merge_pkg::*;
(
    input  logic [CLS_W-1:0] cls_a,
    input  logic [CLS_W-1:0] cls_b,
    input  logic             force_top,
    output logic [CLS_W-1:0] field
);
    logic [CLS_W-1:0] mx;

    always_comb begin
        mx = (cls_a > cls_b) ? cls_a : cls_b;
        if (force_top)            field = CLS_TOP;
        else if (mx > CLS_CLIP)   field = CLS_CLIP;
        else                      field = mx;
    end
endmodule

// File: rtl/trig_merge_final.sv
module trig_merge_final
    import trig_merge_pkg::*;
#(
    parameter int ETOT_W = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   in_valid,
    input  logic [ETOT_W+2*CLS_W+MULT_W:0]         bar_word,
    input  logic [N_EPATCH*CLS_W+CLS_W+MULT_W:0]   end_word,
    input  logic [ETOT_W-1:0]                      etot_thr,
    output logic [2*CLS_W*2-CLS_W:0]               trig_word,
    output logic                                   trig_valid
);
    localparam int B_JET  = 0;
    localparam int B_HT   = B_JET + CLS_W;
    localparam int B_MULT = B_HT + CLS_W;
    localparam int B_ETOT = B_MULT + MULT_W;
    localparam int B_ADJ  = B_ETOT + ETOT_W;
    localparam int E_HT   = N_EPATCH*CLS_W;
    localparam int E_MULT = E_HT + CLS_W;
    localparam int E_ADJ  = E_MULT + MULT_W;

    logic [CLS_W-1:0]  ee_code, jet_f, ht_f;
    logic [MULT_W-1:0] mult_or;
    logic              jet_force, ht_force;
    trig_state_t       st_d, st_q;

    assign mult_or   = bar_word[B_MULT +: MULT_W] | end_word[E_MULT +: MULT_W];
    assign ht_force  = mult_or[MULT_W-1];
    assign jet_force = bar_word[B_ADJ] & end_word[E_ADJ];

    tmf_ecap_jet_coder #(.N_PATCH(N_EPATCH)) u_coder (
        .patch_cls (end_word[N_EPATCH*CLS_W-1:0]),
        .code      (ee_code)
    );

    tmf_class_merge u_jet (
        .cls_a     (bar_word[B_JET +: CLS_W]),
        .cls_b     (ee_code),
        .force_top (jet_force),
        .field     (jet_f)
    );

    tmf_class_merge u_ht (
        .cls_a     (bar_word[B_HT +: CLS_W]),
        .cls_b     (end_word[E_HT +: CLS_W]),
        .force_top (ht_force),
        .field     (ht_f)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.word.jet_cls  = jet_f;
            st_d.word.ht_cls   = ht_f;
            st_d.word.etot_hit = bar_word[B_ETOT +: ETOT_W] > etot_thr;
            st_d.word.ee_code  = ee_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trig_word  = st_q.word;
    assign trig_valid = st_q.valid;
endmodule

// File: rtl/trig_merge_final_chk.sv
module trig_merge_final_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [14:0] bar_word,
    input logic [10:0] end_word,
    input logic [7:0]  etot_thr,
    input logic [6:0]  trig_word,
    input logic        trig_valid
);
    a_r1_reset_clear: assert property (@(posedge clk) !rst_n |-> (trig_word == '0 && !trig_valid));
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> trig_valid);
    a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !trig_valid);
    a_r4_adj_top: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bar_word[14] && end_word[10]) |=> trig_word[1:0] == 2'd3);
    a_r6_mult_top: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (bar_word[5] || end_word[9])) |=> trig_word[3:2] == 2'd3);
    a_r7_etot_flag: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> trig_word[4] == ($past(bar_word[13:6]) > $past(etot_thr)));
    a_r8_ee_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && end_word[5:0] == 6'd0) |=> trig_word[6:5] == 2'd0);
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(trig_word));
endmodule

bind trig_merge_final trig_merge_final_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bar_word(bar_word),
    .end_word(end_word), .etot_thr(etot_thr), .trig_word(trig_word),
    .trig_valid(trig_valid)
);

// File: tb/trig_merge_final_tb.sv
module trig_merge_final_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [14:0] bar_word = '0;
    logic [10:0] end_word = '0;
    logic [7:0]  etot_thr = '0;
    logic [6:0]  trig_word;
    logic        trig_valid;
    int          errors = 0;
    int          checks = 0;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    trig_merge_final u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bar_word(bar_word),
        .end_word(end_word), .etot_thr(etot_thr), .trig_word(trig_word),
        .trig_valid(trig_valid)
    );

    // row: barrel{edge,etot,mult,ht,jet} endcap{edge,mult,ht,C,B,A} thr exp{ee,flag,ht,jet}
    localparam int NV = 14;
    localparam logic [40:0] VEC [NV] = '{
        {1'b0,8'd0,2'd0,2'd0,2'd0,    1'b0,2'd0,2'd0,2'd0,2'd0,2'd0, 8'd0,   2'd0,1'b0,2'd0,2'd0},
        {1'b0,8'd50,2'd0,2'd2,2'd1,   1'b0,2'd0,2'd0,2'd0,2'd0,2'd0, 8'd40,  2'd0,1'b1,2'd2,2'd1},
        {1'b0,8'd40,2'd0,2'd3,2'd3,   1'b0,2'd0,2'd0,2'd0,2'd0,2'd0, 8'd40,  2'd0,1'b0,2'd2,2'd2},
        {1'b0,8'd0,2'd0,2'd0,2'd0,    1'b0,2'd0,2'd1,2'd0,2'd0,2'd1, 8'd255, 2'd1,1'b0,2'd1,2'd1},
        {1'b0,8'd0,2'd0,2'd0,2'd0,    1'b0,2'd0,2'd0,2'd0,2'd2,2'd0, 8'd255, 2'd2,1'b0,2'd0,2'd2},
        {1'b0,8'd0,2'd0,2'd0,2'd0,    1'b0,2'd0,2'd0,2'd3,2'd0,2'd0, 8'd255, 2'd3,1'b0,2'd0,2'd2},
        {1'b0,8'd0,2'd0,2'd0,2'd0,    1'b0,2'd0,2'd0,2'd0,2'd2,2'd2, 8'd255, 2'd3,1'b0,2'd0,2'd2},
        {1'b0,8'd0,2'd0,2'd0,2'd0,    1'b0,2'd0,2'd0,2'd2,2'd0,2'd2, 8'd255, 2'd2,1'b0,2'd0,2'd2},
        {1'b1,8'd0,2'd0,2'd0,2'd0,    1'b1,2'd0,2'd0,2'd0,2'd0,2'd0, 8'd255, 2'd0,1'b0,2'd0,2'd3},
        {1'b1,8'd0,2'd0,2'd0,2'd1,    1'b0,2'd0,2'd0,2'd0,2'd0,2'd0, 8'd255, 2'd0,1'b0,2'd0,2'd1},
        {1'b0,8'd0,2'd1,2'd1,2'd0,    1'b0,2'd2,2'd0,2'd0,2'd0,2'd0, 8'd255, 2'd0,1'b0,2'd3,2'd0},
        {1'b0,8'd0,2'd1,2'd0,2'd0,    1'b0,2'd1,2'd2,2'd0,2'd0,2'd0, 8'd255, 2'd0,1'b0,2'd2,2'd0},
        {1'b0,8'd0,2'd2,2'd0,2'd0,    1'b0,2'd0,2'd0,2'd0,2'd0,2'd0, 8'd255, 2'd0,1'b0,2'd3,2'd0},
        {1'b0,8'd255,2'd0,2'd0,2'd0,  1'b0,2'd0,2'd0,2'd0,2'd0,2'd0, 8'd254, 2'd0,1'b1,2'd0,2'd0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [40:0] v, input logic vld);
        @(negedge clk);
        bar_word = v[40:26];
        end_word = v[25:15];
        etot_thr = v[14:7];
        in_valid = vld;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset word", {1'b0, trig_word}, 8'h00);
        check("R1 reset valid", {7'd0, trig_valid}, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i], 1'b1);
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("R3/R4/R5/R6/R7/R8 row %0d", i), {1'b0, trig_word}, {1'b0, VEC[i][6:0]});
            check("R2 valid after one cycle", {7'd0, trig_valid}, 8'h01);
        end

        // R2: valid low one cycle after an idle cycle
        @(negedge clk);
        check("R2 valid low when idle", {7'd0, trig_valid}, 8'h00);

        // R9: new inputs with in_valid low leave the word unchanged (last row: 7'b0010000)
        drive({1'b1,8'd200,2'd3,2'd3,2'd3, 1'b1,2'd3,2'd3,2'd3,2'd3,2'd3, 8'd0, 7'd0}, 1'b0);
        @(negedge clk);
        @(negedge clk);
        check("R9 hold without valid", {1'b0, trig_word}, 8'h10);

        // R2 latency: not yet visible before the capturing edge
        drive({1'b1,8'd200,2'd3,2'd3,2'd3, 1'b1,2'd3,2'd3,2'd3,2'd3,2'd3, 8'd0, 7'd0}, 1'b1);
        #5;
        check("R2 no zero-cycle path", {7'd0, trig_valid}, 8'h00);
        @(negedge clk);
        in_valid = 1'b0;
        check("R4 R6 R7 R8 all top", {1'b0, trig_word}, 8'h7F);

        // R1: reset mid-run clears the word
        rst_n = 1'b0;
        #3;
        check("R1 async clear", {1'b0, trig_word}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule